// File: doc/BRIEF.md
# Bus Master DMA Cycle Sequencer

This block runs one direct-memory-access transfer per bus tenure on an asynchronous, interlocked bus that uses a master sync and a slave sync. Control logic loads the transfer address, the write word and two cycle-type bits. It then raises `start`. The sequencer asks the arbiter for mastership and waits for the grant. It drives the address, the write data and the C1 control line in a fixed order with timed wait states around the master sync strobe. It holds the strobe until the slave sync arrives through a deskew synchronizer, releases the bus, and then waits for `start` to fall.

There are four transfer types. With C1 high the transfer is a write: a word write, or a byte write in which address bit 0 selects the lane the slave accepts. With C1 low and C0 low it is a plain read. With C1 low and C0 high it is a read-pause that reuses the address phase of the read and continues straight into a write half, with no new arbitration. The sequencer captures read data into a holding register. The holding register leaves the block as a valid/ready stream. The register keeps its word while `rd_ready` is low, and `rd_valid` stays high until a cycle with `rd_ready` high. A later read replaces an unaccepted word, because the bus side is never stalled. After `start` falls, control logic must keep it low for at least two clocks before raising it again.

Top module: `bus_dma_master`

## Requirements
- R1: While `rst_n` is low (asynchronous), every bus-side output and `rd_valid` are 0, and `bus_addr` and `bus_wdata` are 0.
- R2: A tenure begins only on a 0-to-1 transition of `start` seen in the idle state; a `start` already high at reset release launches nothing. While the grant is awaited, only `mst_req` is asserted.
- R3: Write (C1=1): on grant, `addr_en`, `data_en` and `c1_out` rise together; `msyn` follows three cycles later and stays high until the synchronized slave sync is seen. `msyn` and `data_en` then fall together, and `addr_en`/`c1_out` stay two more cycles.
- R4: Read (C1=0): on grant, only `addr_en` rises. `msyn` follows three cycles later and falls when the synchronized slave sync is seen. `bus_rdata` is captured at that edge.
- R5: The slave sync passes through two flip-flops: `msyn` falls no earlier than the third rising clock edge after `ssyn_async` rises.
- R6: At the end of a tenure, `mst_req`, `addr_en`, `c1_out` and `data_en` are all low. The sequencer stays released while `start` stays high, and a new tenure needs `start` low and then high again.
- R7: Read-pause (C1=0, C0=1): after the read half, the sequencer waits for the synchronized slave sync to fall. It then runs the full write sequence of R3 while `addr_en` and `mst_req` stay high throughout, giving exactly two `msyn` pulses per tenure.
- R8: `bus_addr` equals `xfer_addr` while `addr_en` is high and is 0 otherwise. `bus_wdata` equals `xfer_wdata` while `data_en` is high and is 0 otherwise.
- R9: The read data stream holds `rd_data` with `rd_valid` high until a cycle with `rd_ready` high. A new capture replaces an unaccepted word.
- R10: C1 and C0 are latched at launch; changes during a tenure have no effect, and C1=1 means a write whatever C0 is.
- R11: `data_en`, `msyn` and `c1_out` are only ever high while `addr_en` and `mst_req` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, rising edge starts a tenure |
| ctl_c1 | input | 1 | Cycle-type bit: 1 = write |
| ctl_c0 | input | 1 | Cycle-type bit: with C1=0, 1 = read-pause |
| xfer_addr | input | 18 | Transfer address, bit 0 selects byte lane on byte writes |
| xfer_wdata | input | 16 | Word for the write phase |
| grant | input | 1 | Mastership grant from the arbiter |
| ssyn_async | input | 1 | Slave sync, asynchronous |
| bus_rdata | input | 16 | Data from the slave |
| mst_req | output | 1 | Mastership request to the arbiter |
| addr_en | output | 1 | Address driver enable |
| data_en | output | 1 | Data driver enable |
| c1_out | output | 1 | C1 control line to the bus |
| msyn | output | 1 | Master sync strobe |
| bus_addr | output | 18 | Address to drivers, gated by `addr_en` |
| bus_wdata | output | 16 | Data to drivers, gated by `data_en` |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer accepts the read word |
| rd_data | output | 16 | Captured read word |

## Verification
The assertions check on every cycle that the enables are properly nested, that the strobe cannot fall before the two-stage deskew could have delivered the slave sync, that the outputs are gated, that the end of a tenure is clean, and that the read stream keeps its word under back-pressure. Only the bench scenarios can show the exact lengths of the wait states, the two strobe pulses of a read-pause under one grant, the latching of the cycle type while the inputs are changed mid-tenure, the edge-only launch, and the value captured from the bus.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  // Numeric values follow the step order of the sequence.
  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_WAIT_GNT  = 4'd1,
    ST_WR_SETUP  = 4'd2,
    ST_WR_W3     = 4'd3,
    ST_WR_W4     = 4'd4,
    ST_WR_STROBE = 4'd5,
    ST_WR_H6     = 4'd6,
    ST_WR_H7     = 4'd7,
    ST_RELEASE   = 4'd8,
    ST_RD_SETUP  = 4'd9,
    ST_RD_W10    = 4'd10,
    ST_RD_W11    = 4'd11,
    ST_RD_STROBE = 4'd12,
    ST_RD_DROP   = 4'd13,
    ST_RD_TAIL   = 4'd14
  } seq_state_e;

  typedef struct packed {
    logic req;
    logic addr;
    logic data;
    logic c1;
    logic msyn;
  } bus_drive_t;

endpackage

// File: rtl/dmaseq_sync.sv
module dmaseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/dmaseq_fsm.sv
module dmaseq_fsm
  import dmaseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ctl_c1,
  input  logic       ctl_c0,
  input  logic       grant,
  input  logic       ssyn_s,
  output bus_drive_t drv,
  output logic       cap_load
);
  seq_state_e st, nxt;
  logic start_q;
  logic kind_c1, kind_c0;
  logic launch;

  assign launch = (st == ST_IDLE) && start && !start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      start_q <= 1'b1;   // a start already high at reset is not an edge
      kind_c1 <= 1'b0;
      kind_c0 <= 1'b0;
    end else begin
      st      <= nxt;
      start_q <= start;
      if (launch) begin
        kind_c1 <= ctl_c1;
        kind_c0 <= ctl_c0;
      end
    end
  end

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:      if (launch) nxt = ST_WAIT_GNT;
      ST_WAIT_GNT:  if (grant) nxt = kind_c1 ? ST_WR_SETUP : ST_RD_SETUP;
      ST_WR_SETUP:  nxt = ST_WR_W3;
      ST_WR_W3:     nxt = ST_WR_W4;
      ST_WR_W4:     nxt = ST_WR_STROBE;
      ST_WR_STROBE: if (ssyn_s) nxt = ST_WR_H6;
      ST_WR_H6:     nxt = ST_WR_H7;
      ST_WR_H7:     nxt = ST_RELEASE;
      ST_RELEASE:   if (!start) nxt = ST_IDLE;
      ST_RD_SETUP:  nxt = ST_RD_W10;
      ST_RD_W10:    nxt = ST_RD_W11;
      ST_RD_W11:    nxt = ST_RD_STROBE;
      ST_RD_STROBE: if (ssyn_s) nxt = ST_RD_DROP;
      ST_RD_DROP:   nxt = ST_RD_TAIL;
      ST_RD_TAIL: begin
        if (!kind_c0)     nxt = ST_RELEASE;
        else if (!ssyn_s) nxt = ST_WR_SETUP;
      end
      default:      nxt = ST_IDLE;
    endcase
  end

  // Moore decode of the bus-side controls.
  always_comb begin
    drv = '0;
    unique case (st)
      ST_WAIT_GNT:  drv.req = 1'b1;
      ST_WR_SETUP, ST_WR_W3, ST_WR_W4: begin
        drv.req = 1'b1; drv.addr = 1'b1; drv.data = 1'b1; drv.c1 = 1'b1;
      end
      ST_WR_STROBE: begin
        drv.req = 1'b1; drv.addr = 1'b1; drv.data = 1'b1; drv.c1 = 1'b1;
        drv.msyn = 1'b1;
      end
      ST_WR_H6, ST_WR_H7: begin
        drv.req = 1'b1; drv.addr = 1'b1; drv.c1 = 1'b1;
      end
      ST_RD_SETUP, ST_RD_W10, ST_RD_W11, ST_RD_DROP, ST_RD_TAIL: begin
        drv.req = 1'b1; drv.addr = 1'b1;
      end
      ST_RD_STROBE: begin
        drv.req = 1'b1; drv.addr = 1'b1; drv.msyn = 1'b1;
      end
      default: drv = '0;
    endcase
  end

  assign cap_load = (st == ST_RD_STROBE) && ssyn_s;
endmodule

// File: rtl/dmaseq_rxreg.sv
module dmaseq_rxreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready && valid) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_dma_master.sv
module bus_dma_master
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ctl_c1,
  input  logic              ctl_c0,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [DATA_W-1:0] xfer_wdata,
  input  logic              grant,
  input  logic              ssyn_async,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              mst_req,
  output logic              addr_en,
  output logic              data_en,
  output logic              c1_out,
  output logic              msyn,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  bus_drive_t drv;
  logic ssyn_s;
  logic cap_load;

  dmaseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ssyn_async), .q(ssyn_s)
  );

  dmaseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl_c1(ctl_c1),
    .ctl_c0(ctl_c0), .grant(grant), .ssyn_s(ssyn_s),
    .drv(drv), .cap_load(cap_load)
  );

  dmaseq_rxreg #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(cap_load), .din(bus_rdata),
    .ready(rd_ready), .valid(rd_valid), .dout(rd_data)
  );

  assign mst_req   = drv.req;
  assign addr_en   = drv.addr;
  assign data_en   = drv.data;
  assign c1_out    = drv.c1;
  assign msyn      = drv.msyn;
  assign bus_addr  = addr_en ? xfer_addr  : '0;
  assign bus_wdata = data_en ? xfer_wdata : '0;
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ssyn_async,
  input logic              mst_req,
  input logic              addr_en,
  input logic              data_en,
  input logic              c1_out,
  input logic              msyn,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data
);
  AST_NESTED_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en || msyn || c1_out) |-> (addr_en && mst_req)); // R11
  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msyn) |-> $past(ssyn_async, 2)); // R5
  AST_ADDR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_en |-> (bus_addr == '0)); // R8
  AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !data_en |-> (bus_wdata == '0)); // R8
  AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_req) |-> (!addr_en && !data_en && !c1_out)); // R6
  AST_GRANT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_req) |-> (!addr_en && !msyn)); // R2
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid); // R9
  AST_RX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !msyn) |=> $stable(rd_data)); // R9
endmodule

bind bus_dma_master dmaseq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ssyn_async(ssyn_async), .mst_req(mst_req),
  .addr_en(addr_en), .data_en(data_en), .c1_out(c1_out), .msyn(msyn),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/sim_bus_dma_master.sv
module sim_bus_dma_master;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ctl_c1 = 1'b0, ctl_c0 = 1'b0;
  logic [17:0] xfer_addr = '0;
  logic [15:0] xfer_wdata = '0;
  logic grant = 1'b0, ssyn_async = 1'b0;
  logic [15:0] bus_rdata;
  logic mst_req, addr_en, data_en, c1_out, msyn, rd_valid;
  logic rd_ready = 1'b0;
  logic [17:0] bus_addr;
  logic [15:0] bus_wdata, rd_data;

  logic gnt_en = 1'b1, slave_en = 1'b1;
  logic [15:0] slave_word = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bus_dma_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl_c1(ctl_c1), .ctl_c0(ctl_c0),
    .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata), .grant(grant),
    .ssyn_async(ssyn_async), .bus_rdata(bus_rdata), .mst_req(mst_req),
    .addr_en(addr_en), .data_en(data_en), .c1_out(c1_out), .msyn(msyn),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  // Arbiter and slave models: one-cycle responders.
  always @(negedge clk) begin
    grant      <= gnt_en && mst_req;
    ssyn_async <= slave_en && msyn;
  end
  assign bus_rdata = ssyn_async ? slave_word : 16'h0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        c1;
    logic        c0;
    logic [17:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [7:0]  n_addr;
    logic [7:0]  n_data;
    logic [7:0]  n_c1;
    logic [7:0]  n_req;
    logic [3:0]  n_msyn;
    logic        is_rd;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 18'h21234, 16'hA5C3, 16'h0000, 8'd8,  8'd6, 8'd8, 8'd9,  4'd1, 1'b0},
    '{1'b0, 1'b0, 18'h10F0E, 16'h1111, 16'h5A5A, 8'd8,  8'd0, 8'd0, 8'd9,  4'd1, 1'b1},
    '{1'b0, 1'b1, 18'h3FFFE, 16'h00FF, 16'hBEEF, 8'd17, 8'd6, 8'd8, 8'd18, 4'd2, 1'b1},
    '{1'b1, 1'b1, 18'h00001, 16'h1200, 16'h0000, 8'd8,  8'd6, 8'd8, 8'd9,  4'd1, 1'b0},
    '{1'b0, 1'b0, 18'h00000, 16'h7777, 16'hFFFF, 8'd8,  8'd0, 8'd0, 8'd9,  4'd1, 1'b1},
    '{1'b0, 1'b1, 18'h2AAAA, 16'h8000, 16'h0001, 8'd17, 8'd6, 8'd8, 8'd18, 4'd2, 1'b1}
  };

  int n_addr, n_data, n_c1, n_req, n_msyn, n_gate;

  // Launch a tenure, flip the cycle-type inputs one cycle later (R10), and
  // count output cycles until the request is released.
  task automatic run_xfer(input vec_t v);
    logic prev_msyn = 1'b0;
    bit seen = 1'b0;
    n_addr = 0; n_data = 0; n_c1 = 0; n_req = 0; n_msyn = 0; n_gate = 0;
    @(negedge clk);
    ctl_c1 = v.c1; ctl_c0 = v.c0; xfer_addr = v.addr; xfer_wdata = v.wdata;
    slave_word = v.rdata; start = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i == 0) begin ctl_c1 = ~v.c1; ctl_c0 = ~v.c0; end
      if (mst_req) seen = 1'b1;
      if (seen && !mst_req) break;
      n_req  += int'(mst_req);
      n_addr += int'(addr_en);
      n_data += int'(data_en);
      n_c1   += int'(c1_out);
      if (msyn && !prev_msyn) n_msyn++;
      prev_msyn = msyn;
      if (bus_addr  !== (addr_en ? v.addr  : 18'h0)) n_gate++;
      if (bus_wdata !== (data_en ? v.wdata : 16'h0)) n_gate++;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk); rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with start held high across release (R2)
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {mst_req, addr_en, data_en, c1_out, msyn, rd_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 no launch from level", mst_req, 0);
    start = 1'b0;
    repeat (3) @(negedge clk);

    // Table walk: R3 R4 R7 R8 R10
    foreach (TBL[k]) begin
      run_xfer(TBL[k]);
      chk("R3/R4/R7 addr_en cycles", n_addr, TBL[k].n_addr);
      chk("R3/R10 data_en cycles", n_data, TBL[k].n_data);
      chk("R3/R10 c1_out cycles", n_c1, TBL[k].n_c1);
      chk("R7 mst_req cycles", n_req, TBL[k].n_req);
      chk("R5/R7 msyn pulses", n_msyn, TBL[k].n_msyn);
      chk("R8 gating errors", n_gate, 0);
      chk("R6 released", {mst_req, addr_en, c1_out}, 0);
      chk("R4 rd_valid", rd_valid, TBL[k].is_rd);
      if (TBL[k].is_rd) chk("R4 rd_data", rd_data, TBL[k].rdata);
      drain();
      chk("R9 accepted", rd_valid, 0);
    end

    // R2 grant withheld: only the request is raised
    gnt_en = 1'b0;
    @(negedge clk); ctl_c1 = 1'b1; start = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 waiting request", {mst_req, addr_en, data_en, msyn}, 4'b1000);
    #1 rst_n = 1'b0;
    #1 chk("R1 async reset", {mst_req, addr_en}, 0);
    start = 1'b0; gnt_en = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 slave silent: strobe held
    slave_en = 1'b0;
    @(negedge clk); ctl_c1 = 1'b1; ctl_c0 = 1'b0; start = 1'b1;
    repeat (20) @(negedge clk);
    chk("R3 msyn held", {msyn, data_en}, 2'b11);
    slave_en = 1'b1;
    for (int i = 0; i < 50 && mst_req; i++) @(negedge clk);
    // R6 start kept high after release
    repeat (10) @(negedge clk);
    chk("R6 stays released", {mst_req, addr_en}, 0);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 relaunch", mst_req, 1);
    for (int i = 0; i < 50 && mst_req; i++) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);

    // R9 back-pressure: two reads, no accept, second word kept
    run_xfer('{1'b0, 1'b0, 18'h00100, 16'h0, 16'h1234, 8'd8, 8'd0, 8'd0, 8'd9, 4'd1, 1'b1});
    run_xfer('{1'b0, 1'b0, 18'h00102, 16'h0, 16'hC0DE, 8'd8, 8'd0, 8'd0, 8'd9, 4'd1, 1'b1});
    chk("R9 valid held", rd_valid, 1);
    chk("R9 replaced word", rd_data, 16'hC0DE);
    drain();
    chk("R9 drained", rd_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule